// File: doc/BRIEF.md
# Segmented Pointer Offset Adder

This block moves a pointer that is split into a segment byte and an unsigned data byte. A signed two's-complement offset is added to the data byte. The new data byte is always the low byte of that sum. When the addition runs past the top of the unsigned range, the segment steps up by one. When it runs below zero, the segment steps down by one. A carry-enable control can freeze the segment, and the data byte still wraps.

The block is purely combinational. Its results settle within the same clock period that presents the operands, so a register stage outside the block can capture them and feed them back as the next operands on the following edge. The clock input exists only to keep the interface compatible and has no effect on either result. Segment stepping wraps modulo 256, and no segment overflow indication is produced.

Top module: `seg_ptr_adder`

## Requirements
- R1: `data_out` equals (`data_in` + `offset_in`) modulo 256. `data_in` is read as unsigned (0..255) and `offset_in` as a two's-complement signed byte (-128..127).
- R2: With `carry_en` = 1, if `offset_in[7]` = 0 and the unsigned sum `data_in` + `offset_in` is above 255, then `seg_out` = `seg_in` + 1.
- R3: With `carry_en` = 1, if `offset_in[7]` = 1 and the signed result `data_in` + `offset_in` is below 0, then `seg_out` = `seg_in` - 1.
- R4: When neither R2 nor R3 applies, `seg_out` = `seg_in`. This covers in-range moves such as 0x10 + 0x02 and signed overflow of the offset alone such as 0x7F + 0x7F = 0xFE.
- R5: With `carry_en` = 0, `seg_out` = `seg_in` for every operand, and `data_out` still follows R1.
- R6: Segment stepping wraps. Stepping 0xFF up gives 0x00, and stepping 0x00 down gives 0xFF.
- R7: Both outputs depend only on the present inputs and are valid in the same cycle. `clk` does not change them, so a result registered on one edge and fed back gives a chain of adds (0x10, +2 each: 0x12, then 0x14).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, kept for interface compatibility; does not affect results |
| carry_en | input | 1 | 1 lets a wrap step the segment; 0 holds the segment |
| data_in | input | 8 | Unsigned data byte (pointer low part) |
| seg_in | input | 8 | Segment byte |
| offset_in | input | 8 | Signed two's-complement offset |
| data_out | output | 8 | Wrapped low byte of data plus offset |
| seg_out | output | 8 | Segment after any one-step move |

## Verification
Both results are due in the same cycle the operands are applied, with no register on the path. The bench therefore changes the inputs and samples one nanosecond later, well inside the period, and never waits on a clock edge for a result. In the feedback test, an operand comes from a bench register loaded on the rising edge. That result is sampled on the following falling edge, half a period after the register updates. A separate check holds the inputs steady across several edges to show that the clock alone leaves the outputs unchanged.

// File: rtl/seg_ptr_adder_pkg.sv
package seg_ptr_adder_pkg;

  // Direction in which the segment moves after an add.
  typedef enum logic [1:0] {
    SEG_HOLD = 2'd0,
    SEG_UP   = 2'd1,
    SEG_DOWN = 2'd2
  } seg_step_e;

endpackage

// File: rtl/spa_wrap_detect.sv
module spa_wrap_detect #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] offset_in,
  output logic [DATA_W-1:0] sum_out,
  output logic              wrap_up,
  output logic              wrap_down
);
  localparam int EXT_W = DATA_W + 1;

  // Zero-extended add: the top bit tells whether the unsigned sum left the range.
  function automatic logic [EXT_W-1:0] ext_add(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [EXT_W-1:0] wide_sum;
  logic             off_neg;

  always_comb begin
    wide_sum  = ext_add(data_in, offset_in);
    off_neg   = offset_in[DATA_W-1];
    sum_out   = wide_sum[DATA_W-1:0];
    // Positive offset: carry out means the top was crossed.
    wrap_up   = !off_neg &&  wide_sum[DATA_W];
    // Negative offset: missing carry means the result went below zero.
    wrap_down =  off_neg && !wide_sum[DATA_W];
  end
endmodule

// File: rtl/spa_seg_step.sv
module spa_seg_step
  import seg_ptr_adder_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] seg_in,
  input  logic             carry_en,
  input  logic             wrap_up,
  input  logic             wrap_down,
  output seg_step_e        step,
  output logic [SEG_W-1:0] seg_out
);
  function automatic seg_step_e pick_step(input logic en, input logic up, input logic dn);
    if (!en)     return SEG_HOLD;
    else if (up) return SEG_UP;
    else if (dn) return SEG_DOWN;
    else         return SEG_HOLD;
  endfunction

  // Modulo-2^SEG_W step in the chosen direction.
  function automatic logic [SEG_W-1:0] apply_step(input logic [SEG_W-1:0] s, input seg_step_e d);
    case (d)
      SEG_UP:   return s + SEG_W'(1);
      SEG_DOWN: return s - SEG_W'(1);
      default:  return s;
    endcase
  endfunction

  always_comb begin
    step    = pick_step(carry_en, wrap_up, wrap_down);
    seg_out = apply_step(seg_in, step);
  end
endmodule

// File: rtl/seg_ptr_adder.sv
module seg_ptr_adder
  import seg_ptr_adder_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              carry_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [DATA_W-1:0] offset_in,
  output logic [DATA_W-1:0] data_out,
  output logic [SEG_W-1:0]  seg_out
);
  // Named internal events, observed by the bound checker.
  logic      wrap_up;
  logic      wrap_down;
  seg_step_e step;

  spa_wrap_detect #(.DATA_W(DATA_W)) u_wrap (
    .data_in   (data_in),
    .offset_in (offset_in),
    .sum_out   (data_out),
    .wrap_up   (wrap_up),
    .wrap_down (wrap_down)
  );

  spa_seg_step #(.SEG_W(SEG_W)) u_step (
    .seg_in    (seg_in),
    .carry_en  (carry_en),
    .wrap_up   (wrap_up),
    .wrap_down (wrap_down),
    .step      (step),
    .seg_out   (seg_out)
  );
endmodule

// File: rtl/seg_ptr_adder_chk.sv
module seg_ptr_adder_chk
  import seg_ptr_adder_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 8
) (
  input logic              clk,
  input logic              carry_en,
  input logic [DATA_W-1:0] data_in,
  input logic [SEG_W-1:0]  seg_in,
  input logic [DATA_W-1:0] offset_in,
  input logic [DATA_W-1:0] data_out,
  input logic [SEG_W-1:0]  seg_out,
  input logic              wrap_up,
  input logic              wrap_down,
  input seg_step_e         step
);
  // The block has no reset; each property relates present values only.
  AST_DATA_DIFF: assert property (@(posedge clk)
    DATA_W'(data_out - data_in) == offset_in);                                   // R1
  AST_UP_STEP: assert property (@(posedge clk)
    (carry_en && wrap_up) |-> seg_out == SEG_W'(seg_in + SEG_W'(1)));            // R2
  AST_DOWN_STEP: assert property (@(posedge clk)
    (carry_en && wrap_down) |-> seg_out == SEG_W'(seg_in - SEG_W'(1)));          // R3
  AST_NO_UP_ON_NEG: assert property (@(posedge clk)
    offset_in[DATA_W-1] |-> !wrap_up);                                           // R3
  AST_ONE_DIRECTION: assert property (@(posedge clk)
    $onehot0({wrap_up, wrap_down}));                                             // R4
  AST_SEG_HOLD: assert property (@(posedge clk)
    (!wrap_up && !wrap_down) |-> seg_out == seg_in);                             // R4
  AST_EN_LOW_HOLD: assert property (@(posedge clk)
    !carry_en |-> (seg_out == seg_in && step == SEG_HOLD));                      // R5
  AST_STEP_RANGE: assert property (@(posedge clk)
    (SEG_W'(seg_out - seg_in) == '0) || (SEG_W'(seg_out - seg_in) == SEG_W'(1))
    || (SEG_W'(seg_in - seg_out) == SEG_W'(1)));                                 // R6
endmodule

bind seg_ptr_adder seg_ptr_adder_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
  .clk       (clk),
  .carry_en  (carry_en),
  .data_in   (data_in),
  .seg_in    (seg_in),
  .offset_in (offset_in),
  .data_out  (data_out),
  .seg_out   (seg_out),
  .wrap_up   (wrap_up),
  .wrap_down (wrap_down),
  .step      (step)
);

// File: tb/sim_seg_ptr_adder.sv
module sim_seg_ptr_adder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       carry_en = 1'b0;
  logic [7:0] d_drv = 8'h00;
  logic [7:0] seg_in = 8'h00;
  logic [7:0] offset_in = 8'h00;
  logic [7:0] data_out, seg_out;
  logic       fb_mode = 1'b0, fb_load = 1'b0, fb_we = 1'b0;
  logic [7:0] fb_q = 8'h00;
  logic [7:0] data_in;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign data_in = fb_mode ? fb_q : d_drv;

  always @(posedge clk) begin
    if (fb_load)    fb_q <= 8'h10;
    else if (fb_we) fb_q <= data_out;
  end

  seg_ptr_adder u0 (
    .clk(clk), .carry_en(carry_en), .data_in(data_in), .seg_in(seg_in),
    .offset_in(offset_in), .data_out(data_out), .seg_out(seg_out)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h (d=%02h o=%02h s=%02h en=%0b)",
               req, act, exp, data_in, offset_in, seg_in, carry_en);
    end
  endtask

  // Reference model: integer arithmetic with a signed offset.
  task automatic apply_and_check(input int d, input int o, input int s, input bit en);
    int so, total, e_data, e_seg;
    string rq;
    d_drv = 8'(d); offset_in = 8'(o); seg_in = 8'(s); carry_en = en;
    #1;
    so = (o > 127) ? o - 256 : o;
    total = d + so;
    e_data = (total + 256) % 256;
    if (en && total > 255)    begin e_seg = (s + 1) % 256;   rq = "R2"; end
    else if (en && total < 0) begin e_seg = (s + 255) % 256; rq = "R3"; end
    else                      begin e_seg = s;               rq = en ? "R4" : "R5"; end
    check8("R1 data", data_out, 8'(e_data));
    check8(rq, seg_out, 8'(e_seg));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2;
    // Initial state: all zero inputs give zero outputs (R1, R4).
    apply_and_check(0, 0, 0, 1'b0);
    // Directed examples: R4 in range, R1 negative offset, R3 borrow, R2 carry, R4 signed overflow.
    apply_and_check(8'h10, 8'h02, 0, 1'b1);
    apply_and_check(8'h10, 8'hFE, 0, 1'b1);
    apply_and_check(8'h10, 8'hEE, 0, 1'b1);
    apply_and_check(8'hFE, 8'h04, 0, 1'b1);
    apply_and_check(8'h7F, 8'h7F, 0, 1'b1);
    // R6: segment wrap in both directions.
    apply_and_check(8'hFF, 8'h01, 8'hFF, 1'b1);
    check8("R6 up wrap", seg_out, 8'h00);
    apply_and_check(8'h00, 8'hFF, 8'h00, 1'b1);
    check8("R6 down wrap", seg_out, 8'hFF);
    // Exhaustive sweep of data x offset with carry enabled (R1..R4).
    for (int d = 0; d < 256; d++)
      for (int o = 0; o < 256; o++)
        apply_and_check(d, o, (d * 7 + o * 3) % 256, 1'b1);
    // R5: carry disabled, every data byte against a spread of offsets.
    for (int d = 0; d < 256; d++)
      for (int o = 0; o < 256; o += 17)
        apply_and_check(d, o, (d + o) % 256, 1'b0);
    // R7: inputs held across clock edges leave the outputs unchanged.
    apply_and_check(8'hFE, 8'h04, 8'h40, 1'b1);
    repeat (3) begin
      @(posedge clk); #1;
      check8("R7 clock no effect data", data_out, 8'h02);
      check8("R7 clock no effect seg", seg_out, 8'h41);
    end
    // R7: register feedback chain, +2 each cycle from 0x10.
    @(negedge clk);
    fb_mode = 1'b1; fb_load = 1'b1; offset_in = 8'h02; seg_in = 8'h00; carry_en = 1'b1;
    @(negedge clk);
    fb_load = 1'b0; fb_we = 1'b1;
    check8("R7 chain 1", data_out, 8'h12);
    @(negedge clk);
    check8("R7 chain 2", data_out, 8'h14);
    @(negedge clk);
    check8("R7 chain 3", data_out, 8'h16);
    check8("R7 chain seg", seg_out, 8'h00);
    fb_we = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule